// File: doc/BRIEF.md
# Cylinder Pair Stroke Decoder

This block turns a shared crank pulse count into the four actuator outputs of one pair of cylinders. The outputs are the intake valve, the exhaust valve, the spark plug and the fuel injector. The count runs over one complete four-stroke cycle, which takes two crank revolutions. The block works out where the pair is in that cycle and opens the valves, fires the injector or fires the plug for that position.

One elaboration parameter sets the phase. With `POWER_AT_TDC = 1`, the pair starts its power stroke at count zero. With `POWER_AT_TDC = 0`, the pair starts intake at count zero, which is half a cycle later. A four-cylinder engine therefore uses two copies of this block, one of each variant, fed by the same counter.

The spark fires on a single count. An advance request moves that count one earlier and a retard request moves it one later. When the ignition enable is low, every output is held low.

Top module: `cyl_pair_decoder`

## Requirements
- R1: The cycle position is the count itself when `POWER_AT_TDC = 0`, and (count + PULSES_PER_REV) mod (2·PULSES_PER_REV) when `POWER_AT_TDC = 1`. Each stroke covers PULSES_PER_REV/2 positions, in this order: intake (positions 0–5), compression (6–11), power (12–17), exhaust (18–23). The ranges shown are for the default of 12 pulses per revolution.
- R2: `intake_vlv` is high exactly while the pair is in the intake stroke.
- R3: `fuel_inj` is high exactly while the pair is in the intake stroke.
- R4: `exhaust_vlv` is high exactly while the pair is in the exhaust stroke. Both valve outputs are low during compression and during power.
- R5: With neither timing request high, `spark_out` is high at cycle position 12 (the first count of power) and at no other position.
- R6: With only `spark_early` high, `spark_out` is high at cycle position 11 only.
- R7: With only `spark_late` high, `spark_out` is high at cycle position 13 only.
- R8: With `spark_early` and `spark_late` both high, the two requests cancel and the spark stays at position 12.
- R9: While `ign_on` is low, all four outputs are low, whatever the count and the timing requests.
- R10: A count of 24 or more is outside the cycle, and all four outputs are low for it.
- R11: The outputs are combinational in the inputs, so they follow a new count within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| crank_count | input | CNT_W (5) | Shared crank pulse count, 0 to 23 over one cycle |
| ign_on | input | 1 | Ignition enable; when low, all outputs are forced off |
| spark_early | input | 1 | Request to fire the spark one count earlier |
| spark_late | input | 1 | Request to fire the spark one count later |
| intake_vlv | output | 1 | Intake valve drive |
| exhaust_vlv | output | 1 | Exhaust valve drive |
| spark_out | output | 1 | Spark plug drive |
| fuel_inj | output | 1 | Fuel injector drive |

## Verification
The bench builds two copies of the block, one with `POWER_AT_TDC = 1` and one with `POWER_AT_TDC = 0`, and drives both from the same stimulus. Both phase mappings are therefore checked side by side on every count, including the wrap from position 23 to position 0. Each copy is swept through all 32 count values with each combination of the timing requests. This reaches the advanced spark on the last count of compression, the retarded spark inside power, the out-of-range counts and the ignition-off sweep.

// File: rtl/engine_pkg.sv
// Shared types for the cylinder pair decoder.
// Assumes the four strokes are equal in length and follow each other
// in the fixed order intake, compression, power, exhaust.
package engine_pkg;
    typedef enum logic [1:0] {
        STK_INTAKE  = 2'd0,
        STK_COMPRESS = 2'd1,
        STK_POWER   = 2'd2,
        STK_EXHAUST = 2'd3
    } stroke_e;
endpackage

// File: rtl/stroke_locator.sv
// Maps the shared crank count onto this pair's own cycle position and
// stroke. POWER_AT_TDC selects the half-cycle phase shift.
// Assumes the count never needs more than one wrap (count < 2*cycle).
module stroke_locator
    import engine_pkg::*;
#(
    parameter int PULSES_PER_REV = 12,
    parameter int CNT_W          = 5,
    parameter bit POWER_AT_TDC   = 1'b1
) (
    input  logic [CNT_W-1:0] crank_count,
    output logic             pos_valid,
    output logic [CNT_W-1:0] cycle_pos,
    output stroke_e          stroke
);
    localparam int STROKE_LEN = PULSES_PER_REV / 2;
    localparam int CYCLE_LEN  = 2 * PULSES_PER_REV;
    localparam logic [CNT_W-1:0] CYCLE_LIM = CNT_W'(CYCLE_LEN);
    localparam logic [CNT_W-1:0] HALF_CYC  = CNT_W'(PULSES_PER_REV);
    localparam logic [CNT_W-1:0] B_COMP    = CNT_W'(STROKE_LEN);
    localparam logic [CNT_W-1:0] B_POWER   = CNT_W'(2 * STROKE_LEN);
    localparam logic [CNT_W-1:0] B_EXH     = CNT_W'(3 * STROKE_LEN);

    // purpose: flag counts that fall inside one cycle
    always_comb begin
        pos_valid = (crank_count < CYCLE_LIM);
    end

    generate
        if (POWER_AT_TDC) begin : g_power_phase
            // purpose: shift by half a cycle, wrapping at the cycle length
            always_comb begin
                if (crank_count < HALF_CYC)
                    cycle_pos = crank_count + HALF_CYC;
                else
                    cycle_pos = crank_count - HALF_CYC;
            end
        end else begin : g_intake_phase
            // purpose: the count is the cycle position unchanged
            always_comb begin
                cycle_pos = crank_count;
            end
        end
    endgenerate

    // purpose: classify the cycle position into one of the four strokes
    always_comb begin
        if (cycle_pos < B_COMP)
            stroke = STK_INTAKE;
        else if (cycle_pos < B_POWER)
            stroke = STK_COMPRESS;
        else if (cycle_pos < B_EXH)
            stroke = STK_POWER;
        else
            stroke = STK_EXHAUST;
    end
endmodule

// File: rtl/valve_decoder.sv
// Drives the valves and the injector from the current stroke.
// Assumes pos_valid is low for counts outside the cycle.
module valve_decoder
    import engine_pkg::*;
(
    input  stroke_e stroke,
    input  logic    pos_valid,
    input  logic    ign_on,
    output logic    intake_vlv,
    output logic    exhaust_vlv,
    output logic    fuel_inj
);
    logic live;

    // purpose: outputs are live only with ignition on and a valid count
    always_comb begin
        live = ign_on && pos_valid;
    end

    // purpose: decode the stroke into the valve and injector outputs
    always_comb begin
        intake_vlv  = 1'b0;
        exhaust_vlv = 1'b0;
        fuel_inj    = 1'b0;
        if (live) begin
            unique case (stroke)
                STK_INTAKE: begin
                    intake_vlv = 1'b1;
                    fuel_inj   = 1'b1;
                end
                STK_EXHAUST: exhaust_vlv = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spark_timer.sv
// Fires the spark for one cycle position. The nominal position is the
// first count of power; an early or late request moves it by one count.
// Assumes the two requests are mutually exclusive in use; if both are
// high they cancel each other.
module spark_timer #(
    parameter int PULSES_PER_REV = 12,
    parameter int CNT_W          = 5
) (
    input  logic [CNT_W-1:0] cycle_pos,
    input  logic             pos_valid,
    input  logic             ign_on,
    input  logic             spark_early,
    input  logic             spark_late,
    output logic             spark_out
);
    localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(PULSES_PER_REV);
    localparam logic [CNT_W-1:0] EARLY   = CNT_W'(PULSES_PER_REV - 1);
    localparam logic [CNT_W-1:0] LATE    = CNT_W'(PULSES_PER_REV + 1);

    logic [CNT_W-1:0] fire_pos;

    // purpose: choose the firing position from the timing requests
    always_comb begin
        unique case ({spark_early, spark_late})
            2'b10:   fire_pos = EARLY;
            2'b01:   fire_pos = LATE;
            default: fire_pos = NOMINAL;
        endcase
    end

    // purpose: assert the spark on the chosen position only
    always_comb begin
        spark_out = ign_on && pos_valid && (cycle_pos == fire_pos);
    end
endmodule

// File: rtl/cyl_pair_decoder.sv
// Top level: one cylinder pair's actuator decode from the shared crank
// count. POWER_AT_TDC = 1 gives the pair that starts power at count 0;
// POWER_AT_TDC = 0 gives the pair that starts intake there.
// Assumes the count changes only on the system clock.
module cyl_pair_decoder
    import engine_pkg::*;
#(
    parameter int PULSES_PER_REV = 12,
    parameter int CNT_W          = 5,
    parameter bit POWER_AT_TDC   = 1'b1
) (
    input  logic [CNT_W-1:0] crank_count,
    input  logic             ign_on,
    input  logic             spark_early,
    input  logic             spark_late,
    output logic             intake_vlv,
    output logic             exhaust_vlv,
    output logic             spark_out,
    output logic             fuel_inj
);
    logic             pos_valid;
    logic [CNT_W-1:0] cycle_pos;
    stroke_e          stroke;

    stroke_locator #(
        .PULSES_PER_REV(PULSES_PER_REV),
        .CNT_W(CNT_W),
        .POWER_AT_TDC(POWER_AT_TDC)
    ) u_locate (
        .crank_count(crank_count),
        .pos_valid(pos_valid),
        .cycle_pos(cycle_pos),
        .stroke(stroke)
    );

    valve_decoder u_valves (
        .stroke(stroke),
        .pos_valid(pos_valid),
        .ign_on(ign_on),
        .intake_vlv(intake_vlv),
        .exhaust_vlv(exhaust_vlv),
        .fuel_inj(fuel_inj)
    );

    spark_timer #(
        .PULSES_PER_REV(PULSES_PER_REV),
        .CNT_W(CNT_W)
    ) u_spark (
        .cycle_pos(cycle_pos),
        .pos_valid(pos_valid),
        .ign_on(ign_on),
        .spark_early(spark_early),
        .spark_late(spark_late),
        .spark_out(spark_out)
    );
endmodule

// File: rtl/cyl_pair_chk.sv
// Checker for cyl_pair_decoder. The block is combinational, so the
// checks are immediate ones, evaluated whenever an input or output
// changes and skipped while any of them is unknown.
module cyl_pair_chk #(
    parameter int PULSES_PER_REV = 12,
    parameter int CNT_W          = 5
) (
    input logic [CNT_W-1:0] crank_count,
    input logic             ign_on,
    input logic             intake_vlv,
    input logic             exhaust_vlv,
    input logic             spark_out,
    input logic             fuel_inj
);
    localparam logic [CNT_W-1:0] CYCLE_LIM = CNT_W'(2 * PULSES_PER_REV);

    // purpose: cross-check the outputs of the separate decode units
    always_comb begin
        if (!$isunknown({crank_count, ign_on, intake_vlv, exhaust_vlv, spark_out, fuel_inj})) begin
            if (!ign_on)
                a_r9_ign_off_quiet: assert ({intake_vlv, exhaust_vlv, spark_out, fuel_inj} == 4'b0000);
            if (crank_count >= CYCLE_LIM)
                a_r10_out_of_range_quiet: assert ({intake_vlv, exhaust_vlv, spark_out, fuel_inj} == 4'b0000);
            a_r4_valves_exclusive: assert (!(intake_vlv && exhaust_vlv));
            a_r3_inj_with_intake: assert (fuel_inj == intake_vlv);
            a_r5_spark_valves_shut: assert (!(spark_out && (intake_vlv || exhaust_vlv)));
        end
    end
endmodule

bind cyl_pair_decoder cyl_pair_chk #(
    .PULSES_PER_REV(PULSES_PER_REV),
    .CNT_W(CNT_W)
) u_chk (
    .crank_count(crank_count),
    .ign_on(ign_on),
    .intake_vlv(intake_vlv),
    .exhaust_vlv(exhaust_vlv),
    .spark_out(spark_out),
    .fuel_inj(fuel_inj)
);

// File: tb/cyl_pair_decoder_tb.sv
// Scoreboard bench: the driver applies one stimulus per clock and
// pushes the expected outputs of both phase variants; the monitor pops
// and compares at the falling edge.
module cyl_pair_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;

    typedef struct {
        int         cnt;
        logic       ign;
        logic [1:0] mode;     // {early, late}
        logic [3:0] exp_pwr;  // {fi, sp, vo, vi}
        logic [3:0] exp_int;
    } item_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [CNT_W-1:0] crank_count = '0;
    logic ign_on = 1'b0, spark_early = 1'b0, spark_late = 1'b0;
    logic vi_p, vo_p, sp_p, fi_p, vi_i, vo_i, sp_i, fi_i;

    int checks = 0;
    int errors = 0;
    item_t sb_q[$];

    cyl_pair_decoder #(.POWER_AT_TDC(1'b1)) u_dut (
        .crank_count(crank_count), .ign_on(ign_on),
        .spark_early(spark_early), .spark_late(spark_late),
        .intake_vlv(vi_p), .exhaust_vlv(vo_p), .spark_out(sp_p), .fuel_inj(fi_p)
    );

    cyl_pair_decoder #(.POWER_AT_TDC(1'b0)) u_dut_alt (
        .crank_count(crank_count), .ign_on(ign_on),
        .spark_early(spark_early), .spark_late(spark_late),
        .intake_vlv(vi_i), .exhaust_vlv(vo_i), .spark_out(sp_i), .fuel_inj(fi_i)
    );

    // Reference built from the requirements (R1..R10)
    function automatic logic [3:0] model(bit pwr, int c, logic ign, logic [1:0] mode);
        int pos;
        int fire;
        logic [3:0] r;
        r = 4'b0000;
        if (!ign || c >= 24) return r;
        pos = pwr ? (c + 12) % 24 : c;
        fire = (mode == 2'b10) ? 11 : (mode == 2'b01) ? 13 : 12;
        if (pos < 6) begin r[0] = 1'b1; r[3] = 1'b1; end
        if (pos >= 18) r[1] = 1'b1;
        if (pos == fire) r[2] = 1'b1;
        return r;
    endfunction

    function automatic string tag_for(int bitno, item_t it);
        if (!it.ign) return "R9";
        if (it.cnt >= 24) return "R10";
        case (bitno)
            0: return "R2 R1 R11";
            1: return "R4 R1";
            3: return "R3";
            default: case (it.mode)
                2'b10: return "R6";
                2'b01: return "R7";
                2'b11: return "R8";
                default: return "R5";
            endcase
        endcase
    endfunction

    task automatic drive(int c, logic ign, logic [1:0] mode);
        item_t it;
        @(posedge clk);
        crank_count = CNT_W'(c);
        ign_on      = ign;
        spark_early = mode[1];
        spark_late  = mode[0];
        it.cnt  = c;
        it.ign  = ign;
        it.mode = mode;
        it.exp_pwr = model(1'b1, c, ign, mode);
        it.exp_int = model(1'b0, c, ign, mode);
        sb_q.push_back(it);
    endtask

    // Monitor: compare each output of both variants half a cycle later
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [3:0] act_p, act_i;
            it = sb_q.pop_front();
            act_p = {fi_p, sp_p, vo_p, vi_p};
            act_i = {fi_i, sp_i, vo_i, vi_i};
            for (int b = 0; b < 4; b++) begin
                checks += 2;
                if (act_p[b] !== it.exp_pwr[b]) begin
                    errors++;
                    $display("FAIL %s power-phase cnt=%0d out%0d actual=%b expected=%b",
                             tag_for(b, it), it.cnt, b, act_p[b], it.exp_pwr[b]);
                end
                if (act_i[b] !== it.exp_int[b]) begin
                    errors++;
                    $display("FAIL %s intake-phase cnt=%0d out%0d actual=%b expected=%b",
                             tag_for(b, it), it.cnt, b, act_i[b], it.exp_int[b]);
                end
            end
        end
    end

    initial begin
        // Initial state: ignition off (R9)
        drive(0, 1'b0, 2'b00);
        // Each timing mode over all counts, including out of range (R5-R8, R10)
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 32; c++)
                drive(c, 1'b1, 2'(m));
        // Ignition off sweep with timing requests active (R9)
        for (int c = 0; c < 32; c++)
            drive(c, 1'b0, 2'(c % 3));
        // Rapid count changes across the wrap, one per clock (R11)
        for (int k = 0; k < 30; k++)
            drive((k * 7 + 20) % 24, 1'b1, 2'(k % 4));
        @(posedge clk);
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule